// File: doc/BRIEF.md
# BCD Time-of-Day Register File

This block is a bank of eight byte-wide timekeeping registers placed at the top eight addresses of a larger byte-addressed memory window. It keeps seconds, minutes, hours, day of week, day of month, month and a two-digit year. It also holds a control byte and a software flag. All time fields are presented to the bus in BCD. Internally the fields are held as binary counters, and the conversion to BCD happens on the read path.

A one-cycle `sec_tick` pulse advances the time by one second. The carry runs from seconds through minutes and hours into the day of week and the date. From the date it carries into the month and then the year. Month lengths follow the calendar, with a four-year leap rule. Each field write is decoded from BCD and checked against that field's legal range. An out-of-range value is silently dropped.

Bit 7 of the seconds register is a stop bit. It is held by a two-state controller with states `TOD_RUN` and `TOD_HALT`. A seconds write with bit 7 set takes the transition `RUN_TO_HALT`. A seconds write with bit 7 clear takes `HALT_TO_RUN`. Every other cycle holds the current state. In `TOD_HALT`, ticks are ignored and the stored time is kept intact.

Top module: `tod_bcd_regs`

## Requirements
- R1: The registers respond only when the upper address bits are all ones, and the low three bits select the register: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day-of-week/flag, 5 date, 6 month, 7 year. Any other address reads 0x00, and a write to it changes nothing.
- R2: A control write stores (data AND 0x5F) OR 0x90, and the control register reads back that stored byte.
- R3: A seconds write always latches bit 7 as the stop bit. The time is updated only when the low seven bits decode to 0–59. Reading seconds returns the stop bit in bit 7, ORed with the BCD seconds.
- R4: In `TOD_HALT`, ticks change no time field. After the stop bit is cleared, counting resumes from the held time.
- R5: Each field is decoded as tens×10+units from its own bits, and a nibble above 9 counts at its weight. Minutes use bits 6:0 and accept 0–59. Hours use bits 5:0 and accept 0–23. Date uses bits 5:0 and accepts any nonzero value. Month uses bits 4:0 and accepts 1–12. Year uses bits 7:0 and accepts 0–99.
- R6: A write whose decoded value is out of range leaves every time field unchanged.
- R7: A read always returns the canonical BCD of the stored value, so writing 0x1A to seconds reads back as 0x20.
- R8: The day-of-week register stores bits 2:0 with no range check and stores bit 6 as an independent flag. A read returns (flag<<6) OR day.
- R9: On a tick in `TOD_RUN`, seconds wrap 59→0 into minutes, minutes wrap 59→0 into hours, and hours wrap 23→0 into the day of week and the date. The day of week steps to 1 from 7 (or from 0) and otherwise adds 1.
- R10: The date rolls to 1 and carries into the month when it has reached the month length or gone past it. Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when year mod 4 is 0 and 28 days otherwise. All other months have 31 days. Month 12 rolls to 1, and year 99 rolls to 0.
- R11: A write into the register window in the same cycle as a tick takes effect, and that tick is discarded.
- R12: Reset gives 00:00:00, date 01, month 01, year 00, day 1, control 0x00, flag 0 and state `TOD_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| sec_tick | input | 1 | One-second advance pulse |

## Verification
A corrupted counter or a wrong carry reaches `bus_rdata` on the first read of that register after the clock edge that caused it. The bench reads some register on every cycle against a behavioural calendar model, so an error shows within one cycle whenever that register is addressed. A stop bit stuck in the wrong state shows up in two ways: bit 7 of the seconds read is wrong, and the seconds value drifts from the model on the next tick. A range check that is too loose or too tight makes the field read back differently from the model right after the write.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_SEC  = 3'd1,
        REG_MIN  = 3'd2,
        REG_HOUR = 3'd3,
        REG_WDAY = 3'd4,
        REG_DATE = 3'd5,
        REG_MON  = 3'd6,
        REG_YEAR = 3'd7
    } tod_reg_e;

    typedef enum logic {
        TOD_RUN  = 1'b0,
        TOD_HALT = 1'b1
    } run_state_e;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
        logic [2:0] wday;
        logic [5:0] date;
        logic [3:0] mon;
        logic [6:0] year;
    } tod_time_t;

    localparam tod_time_t TOD_RESET = '{sec: 6'd0, min: 6'd0, hour: 5'd0,
                                        wday: 3'd1, date: 6'd1, mon: 4'd1,
                                        year: 7'd0};

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] n);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = n / 7'd10;
        units = n - tens * 7'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic [5:0] month_days(input logic [3:0] mon,
                                              input logic [6:0] year);
        logic [5:0] d;
        unique case (mon)
            4'd4, 4'd6, 4'd9, 4'd11: d = 6'd30;
            4'd2:                    d = (year[1:0] == 2'b00) ? 6'd29 : 6'd28;
            default:                 d = 6'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tod_write_filter.sv
module tod_write_filter
    import tod_pkg::*;
(
    input  tod_reg_e   wr_sel,
    input  logic [7:0] wr_data,
    input  tod_time_t  cur,
    output tod_time_t  cand,
    output logic       field_ok
);
    logic [7:0] val;

    always_comb begin
        cand     = cur;
        val      = 8'd0;
        field_ok = 1'b0;
        unique case (wr_sel)
            REG_SEC: begin
                val      = bcd_to_bin({1'b0, wr_data[6:0]});
                field_ok = (val <= 8'd59);
                cand.sec = val[5:0];
            end
            REG_MIN: begin
                val      = bcd_to_bin({1'b0, wr_data[6:0]});
                field_ok = (val <= 8'd59);
                cand.min = val[5:0];
            end
            REG_HOUR: begin
                val       = bcd_to_bin({2'b0, wr_data[5:0]});
                field_ok  = (val <= 8'd23);
                cand.hour = val[4:0];
            end
            REG_WDAY: begin
                val       = {5'd0, wr_data[2:0]};
                field_ok  = 1'b1;
                cand.wday = val[2:0];
            end
            REG_DATE: begin
                val       = bcd_to_bin({2'b0, wr_data[5:0]});
                field_ok  = (val != 8'd0);
                cand.date = val[5:0];
            end
            REG_MON: begin
                val      = bcd_to_bin({3'b0, wr_data[4:0]});
                field_ok = (val >= 8'd1) && (val <= 8'd12);
                cand.mon = val[3:0];
            end
            REG_YEAR: begin
                val       = bcd_to_bin(wr_data);
                field_ok  = (val <= 8'd99);
                cand.year = val[6:0];
            end
            REG_CTRL: begin
                field_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tod_rollover.sv
module tod_rollover
    import tod_pkg::*;
(
    input  tod_time_t cur,
    output tod_time_t nxt
);
    logic [5:0] mdays;

    always_comb begin
        mdays = month_days(cur.mon, cur.year);
        nxt   = cur;
        if (cur.sec != 6'd59) begin
            nxt.sec = cur.sec + 6'd1;
        end else begin
            nxt.sec = 6'd0;
            if (cur.min != 6'd59) begin
                nxt.min = cur.min + 6'd1;
            end else begin
                nxt.min = 6'd0;
                if (cur.hour != 5'd23) begin
                    nxt.hour = cur.hour + 5'd1;
                end else begin
                    nxt.hour = 5'd0;
                    nxt.wday = (cur.wday >= 3'd7 || cur.wday == 3'd0) ? 3'd1 : cur.wday + 3'd1;
                    if (cur.date >= mdays) begin
                        nxt.date = 6'd1;
                        if (cur.mon != 4'd12) begin
                            nxt.mon = cur.mon + 4'd1;
                        end else begin
                            nxt.mon  = 4'd1;
                            nxt.year = (cur.year == 7'd99) ? 7'd0 : cur.year + 7'd1;
                        end
                    end else begin
                        nxt.date = cur.date + 6'd1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tod_read_mux.sv
module tod_read_mux
    import tod_pkg::*;
(
    input  logic       in_win,
    input  tod_reg_e   rd_sel,
    input  tod_time_t  cur,
    input  logic       halt,
    input  logic [7:0] ctrl,
    input  logic       flag,
    output logic [7:0] rdata
);
    always_comb begin
        rdata = 8'h00;
        if (in_win) begin
            unique case (rd_sel)
                REG_CTRL: rdata = ctrl;
                REG_SEC:  rdata = {halt, 7'd0} | bin_to_bcd({1'b0, cur.sec});
                REG_MIN:  rdata = bin_to_bcd({1'b0, cur.min});
                REG_HOUR: rdata = bin_to_bcd({2'b0, cur.hour});
                REG_WDAY: rdata = {1'b0, flag, 3'b000, cur.wday};
                REG_DATE: rdata = bin_to_bcd({1'b0, cur.date});
                REG_MON:  rdata = bin_to_bcd({3'b0, cur.mon});
                REG_YEAR: rdata = bin_to_bcd(cur.year);
            endcase
        end
    end
endmodule

// File: rtl/tod_bcd_regs.sv
module tod_bcd_regs
    import tod_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic              sec_tick
);
    localparam int SEL_W = 3;

    logic       in_win;
    tod_reg_e   sel;
    logic       win_we;
    logic       stop_wr;
    run_state_e state_q, state_d;
    logic       adv_en;
    logic       halt;
    tod_time_t  time_q, time_nxt, cand;
    logic       field_ok;
    logic [7:0] ctrl_q;
    logic       flag_q;

    assign in_win  = &bus_addr[ADDR_W-1:SEL_W];
    assign sel     = tod_reg_e'(bus_addr[SEL_W-1:0]);
    assign win_we  = bus_we & in_win;
    assign stop_wr = win_we && (sel == REG_SEC);

    // Next-state logic of the run/halt controller
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOD_RUN:  if (stop_wr && bus_wdata[7])  state_d = TOD_HALT;
            TOD_HALT: if (stop_wr && !bus_wdata[7]) state_d = TOD_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TOD_RUN;
        else        state_q <= state_d;
    end

    // Controller outputs
    always_comb begin
        halt   = (state_q == TOD_HALT);
        adv_en = (state_q == TOD_RUN) && sec_tick && !win_we;
    end

    tod_write_filter u_filter (
        .wr_sel   (sel),
        .wr_data  (bus_wdata),
        .cur      (time_q),
        .cand     (cand),
        .field_ok (field_ok)
    );

    tod_rollover u_roll (
        .cur (time_q),
        .nxt (time_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= TOD_RESET;
            ctrl_q <= 8'h00;
            flag_q <= 1'b0;
        end else begin
            if (win_we && sel == REG_CTRL) ctrl_q <= (bus_wdata & 8'h5F) | 8'h90;
            if (win_we && sel == REG_WDAY) flag_q <= bus_wdata[6];
            if (win_we) begin
                if (field_ok) time_q <= cand;
            end else if (adv_en) begin
                time_q <= time_nxt;
            end
        end
    end

    tod_read_mux u_rd (
        .in_win (in_win),
        .rd_sel (sel),
        .cur    (time_q),
        .halt   (halt),
        .ctrl   (ctrl_q),
        .flag   (flag_q),
        .rdata  (bus_rdata)
    );

    assert_ctrl_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && sel == REG_CTRL) |=> (ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]));

    assert_halt_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TOD_HALT && !win_we) |=> $stable(time_q));

    assert_field_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (time_q.sec <= 6'd59 && time_q.min <= 6'd59 && time_q.hour <= 5'd23 &&
         time_q.date != 6'd0 && time_q.mon >= 4'd1 && time_q.mon <= 4'd12 &&
         time_q.year <= 7'd99));

    assert_reject_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && !field_ok) |=> $stable(time_q));

    assert_tick_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && time_q.sec != 6'd59) |=> (time_q.sec == 6'($past(time_q.sec) + 6'd1)));

    assert_tick_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (win_we && sel == REG_CTRL && sec_tick) |=> $stable(time_q));
endmodule

// File: tb/test_tod_bcd_regs.sv
module test_tod_bcd_regs;
    localparam int AW = 13;
    localparam logic [AW-1:0] BASE = {{(AW-3){1'b1}}, 3'b000};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic          we = 1'b0;
    logic          tick = 1'b0;
    logic [7:0]    rdata;

    int vecs = 0;
    int bad  = 0;

    // Behavioural reference state
    int m_sec = 0, m_min = 0, m_hour = 0, m_dow = 1, m_date = 1, m_mon = 1, m_year = 0;
    int m_ctrl = 0, m_flag = 0, m_stop = 0;

    always #2 clk = ~clk;

    tod_bcd_regs #(.ADDR_W(AW)) i_tod_bcd_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_we    (we),
        .bus_rdata (rdata),
        .sec_tick  (tick)
    );

    function automatic int b2n(input int v);
        return ((v >> 4) & 15) * 10 + (v & 15);
    endfunction

    function automatic int n2b(input int n);
        return ((n / 10) << 4) | (n % 10);
    endfunction

    function automatic int mlen(input int mo, input int yr);
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        return 31;
    endfunction

    function automatic bit inwin(input logic [AW-1:0] a);
        return (a[AW-1:3] == {(AW-3){1'b1}});
    endfunction

    function automatic int mread(input logic [AW-1:0] a);
        if (!inwin(a)) return 0;
        case (a[2:0])
            3'd0: return m_ctrl;
            3'd1: return (m_stop << 7) | n2b(m_sec);
            3'd2: return n2b(m_min);
            3'd3: return n2b(m_hour);
            3'd4: return (m_flag << 6) | m_dow;
            3'd5: return n2b(m_date);
            3'd6: return n2b(m_mon);
            default: return n2b(m_year);
        endcase
    endfunction

    task automatic mwrite(input int off, input int d);
        int v;
        case (off)
            0: m_ctrl = (d & 'h5F) | 'h90;
            1: begin v = b2n(d & 'h7F); if (v <= 59) m_sec = v; m_stop = (d >> 7) & 1; end
            2: begin v = b2n(d & 'h7F); if (v <= 59) m_min = v; end
            3: begin v = b2n(d & 'h3F); if (v <= 23) m_hour = v; end
            4: begin m_dow = d & 7; m_flag = (d >> 6) & 1; end
            5: begin v = b2n(d & 'h3F); if (v != 0) m_date = v; end
            6: begin v = b2n(d & 'h1F); if (v >= 1 && v <= 12) m_mon = v; end
            default: begin v = b2n(d & 'hFF); if (v <= 99) m_year = v; end
        endcase
    endtask

    task automatic madvance();
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0; m_hour++;
        if (m_hour < 24) return;
        m_hour = 0;
        m_dow = (m_dow >= 7 || m_dow == 0) ? 1 : m_dow + 1;
        if (m_date >= mlen(m_mon, m_year)) begin
            m_date = 1; m_mon++;
            if (m_mon > 12) begin m_mon = 1; m_year = (m_year + 1) % 100; end
        end else begin
            m_date++;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hour = 0; m_dow = 1; m_date = 1; m_mon = 1;
            m_year = 0; m_ctrl = 0; m_flag = 0; m_stop = 0;
        end else if (we && inwin(addr)) begin
            mwrite(int'(addr[2:0]), int'(wdata));
        end else if (tick && m_stop == 0) begin
            madvance();
        end
    end

    task automatic step(input logic [AW-1:0] a, input logic [7:0] d, input bit w,
                        input bit t, input string tag);
        int exp;
        @(negedge clk);
        addr = a; wdata = d; we = w; tick = t;
        #1;
        vecs++;
        exp = mread(a);
        if (rdata !== 8'(exp)) begin
            bad++;
            $display("FAIL %s addr=%h got=%h expected=%h", tag, a, rdata, 8'(exp));
        end
    endtask

    task automatic wr(input int off, input logic [7:0] d, input string tag);
        step(BASE | AW'(off), d, 1'b1, 1'b0, tag);
    endtask

    task automatic rd_all(input string tag);
        for (int k = 0; k < 8; k++) step(BASE | AW'(k), 8'h00, 1'b0, 1'b0, tag);
    endtask

    task automatic tk(input int n, input int off, input string tag);
        for (int k = 0; k < n; k++) step(BASE | AW'(off), 8'h00, 1'b0, 1'b1, tag);
    endtask

    task automatic settime(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                           input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] yr,
                           input logic [7:0] dw, input string tag);
        wr(3, h, tag); wr(2, mi, tag); wr(1, s, tag);
        wr(6, mo, tag); wr(5, dt, tag); wr(7, yr, tag); wr(4, dw, tag);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL R12 watchdog: got no completion, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rd_all("R12 reset state");

        // R1 window decode
        step('0, 8'h00, 1'b0, 1'b0, "R1 outside read");
        step(BASE - 1, 8'h55, 1'b1, 1'b0, "R1 outside write");
        step(AW'(5), 8'h12, 1'b1, 1'b0, "R1 outside write");
        rd_all("R1 window unchanged");

        // R2 control byte
        wr(0, 8'hFF, "R2"); step(BASE, 8'h00, 1'b0, 1'b0, "R2 ctrl FF");
        wr(0, 8'h00, "R2"); step(BASE, 8'h00, 1'b0, 1'b0, "R2 ctrl 00");

        // R10 non-leap February end, with R9 day-of-week wrap
        settime(8'h23, 8'h59, 8'h58, 8'h28, 8'h02, 8'h03, 8'h07, "R5 set");
        tk(3, 5, "R10 feb 28 non-leap");
        rd_all("R9 carry into march");

        // R10 leap February
        settime(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h04, 8'h03, "R5 set");
        tk(1, 5, "R10 leap feb");
        rd_all("R10 feb 29");
        wr(1, 8'h59, "R3"); wr(2, 8'h59, "R5"); wr(3, 8'h23, "R5");
        tk(1, 6, "R10 leap end");
        rd_all("R10 march 1");

        // R10 thirty-day month and year wrap
        settime(8'h23, 8'h59, 8'h59, 8'h30, 8'h04, 8'h10, 8'h00, "R5 set");
        tk(1, 6, "R10 april 30");
        rd_all("R9 day from 0");
        settime(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99, 8'h05, "R5 set");
        tk(2, 7, "R10 year 99");
        rd_all("R10 new year");

        // R7 non-canonical BCD, R3 seconds range
        wr(1, 8'h1A, "R7"); step(BASE | 1, 8'h00, 1'b0, 1'b0, "R7 0x1A reads 0x20");
        wr(1, 8'h60, "R3"); step(BASE | 1, 8'h00, 1'b0, 1'b0, "R3 reject 60");

        // R5 and R6 range rejects
        wr(2, 8'h5A, "R6"); wr(3, 8'h24, "R6"); wr(3, 8'h0F, "R5");
        wr(5, 8'h00, "R6"); wr(6, 8'h13, "R6"); wr(6, 8'h00, "R6");
        wr(7, 8'hA0, "R6"); wr(7, 8'h5A, "R5"); wr(5, 8'h3F, "R5");
        rd_all("R6 after rejects");

        // R4 stop bit
        wr(1, 8'hB0, "R4 halt");
        tk(5, 1, "R4 frozen");
        wr(1, 8'hF5, "R4 bad value keeps stop");
        tk(2, 1, "R4 frozen");
        wr(1, 8'h7F, "R4 resume unchanged");
        tk(3, 1, "R4 counting");
        rd_all("R4 after resume");

        // R8 day register and flag
        wr(4, 8'h45, "R8"); step(BASE | 4, 8'h00, 1'b0, 1'b0, "R8 flag+day");
        wr(4, 8'hBF, "R8"); step(BASE | 4, 8'h00, 1'b0, 1'b0, "R8 no flag");
        wr(4, 8'h40, "R8"); step(BASE | 4, 8'h00, 1'b0, 1'b0, "R8 day 0");

        // R11 write beats tick
        step(BASE | 2, 8'h10, 1'b1, 1'b1, "R11");
        step(BASE | 0, 8'h33, 1'b1, 1'b1, "R11");
        rd_all("R11 tick dropped");

        // Mixed traffic
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] a;
            int r;
            r = $urandom_range(0, 99);
            a = (r < 92) ? (BASE | AW'($urandom_range(0, 7))) : AW'($urandom_range(0, 2000));
            step(a, 8'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1),
                 "R9 mixed");
        end
        for (int i = 0; i < 4000; i++)
            step(BASE | AW'(i % 8), 8'h00, 1'b0, 1'b1, "R9 run");

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule